// File: doc/BRIEF.md
# Parallel Port Service-Interrupt Controller

This block is the host-side control and interrupt logic of a FIFO-backed parallel port. It holds one control byte with four fields: a three-bit operating mode, a fault-interrupt mask, a DMA enable and a service hold bit. The service hold bit is both an enable and a status flag. Software clears it to arm the port. The hardware sets it again when any service cause fires: a DMA terminal count, a FIFO occupancy threshold, or a FIFO misuse error. Setting it blocks further service interrupts and stops DMA requests until software clears it again.

The block reads FIFO occupancy as a byte count. It converts the count into transfer words, whose size comes from an implementation ID, and uses them to compute direction-dependent full and empty flags. It also watches an active-low fault pin and raises an interrupt when the pin falls while the fault interrupt is unmasked. Unmasking the fault interrupt while the pin is already low also raises an interrupt, so a fault that arrives between a read and a write of the control byte is not lost. A configuration input selects the interrupt style. In pulsed style, each event gives a fixed-width high pulse on the interrupt line. In level style, the line follows latched pending conditions until software masks them.

Top module: `ppt_svc_irq_ctl`

## Requirements
- R1: `dma_req_en` is 1 exactly when control bit 3 (DMA enable) is 1 and control bit 2 (service hold) is 0. A `dma_tc` pulse while DMA runs sets service hold, drops `dma_req_en` on the next cycle and raises an interrupt. While DMA is enabled, the threshold causes are ignored.
- R2: In the forward direction (`dir`=0) with DMA disabled and service hold at 0, the block sets service hold and interrupts once the free space, counted in whole words, is at least `wr_thresh`.
- R3: In the reverse direction (`dir`=1) with DMA disabled and service hold at 0, the block sets service hold and interrupts once the held data, counted in whole words, is at least `rd_thresh`.
- R4: Software writing service hold to 1 never produces an interrupt. While service hold is 1, no threshold condition produces an interrupt.
- R5: Forward direction: read bit 1 (full) is 1 when fewer than one word of space is free. Read bit 0 (empty) is 1 when the FIFO holds zero bytes.
- R6: Reverse direction: full is 1 only when every byte of the FIFO is occupied. Empty is 1 when fewer than one word of data is held.
- R7: `impl_id` sets the word size: 0 gives 2 bytes, 1 gives 1 byte, 2 gives 4 bytes, and any other value gives 1 byte.
- R8: With control bit 4 (fault mask) at 0, a falling edge on `fault_n` raises an interrupt. This takes three clock edges, two for synchronisation and one for the event register. With the mask at 1, a falling edge has no effect.
- R9: Writing the fault mask from 1 to 0 while `fault_n` is low raises an interrupt right after that write.
- R10: In pulsed style (`level_irq`=0), each event drives `irq` high for exactly PULSE_CYC cycles (default 4).
- R11: In level style (`level_irq`=1), `irq` is the OR of two terms. The first is the pending service flag, but only when mode bits 7:5 are not 000 or 001. The second is the pending fault flag. Writing service hold to 1 clears the pending service flag, and writing the fault mask to 1 clears the pending fault flag.
- R12: A FIFO write strobe while forward-full, or a FIFO read strobe while reverse-empty, forces both full and empty to read 1 and counts as a service cause. Any later control write clears the error.
- R13: After reset, the control byte reads mode 000, fault mask 1, DMA enable 0 and service hold 1 (0x15 with an empty forward FIFO). `irq` and `dma_req_en` are both 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write value: [7:5] mode, [4] fault mask, [3] DMA enable, [2] service hold |
| reg_rdata | output | 8 | Control byte readback, with [1] full and [0] empty |
| dir | input | 1 | Transfer direction, 0 forward, 1 reverse |
| fifo_bytes | input | CNT_W | FIFO occupancy in bytes (0..FIFO_BYTES) |
| impl_id | input | 3 | Implementation ID that selects the word size |
| wr_thresh | input | CNT_W | Forward threshold in free words |
| rd_thresh | input | CNT_W | Reverse threshold in held words |
| fifo_wr_stb | input | 1 | Host write into the FIFO this cycle |
| fifo_rd_stb | input | 1 | Host read from the FIFO this cycle |
| dma_tc | input | 1 | DMA terminal count pulse |
| fault_n | input | 1 | Asynchronous active-low fault pin |
| level_irq | input | 1 | 1 selects level interrupts, 0 selects pulsed interrupts |
| irq | output | 1 | Interrupt line |
| dma_req_en | output | 1 | Permission for the DMA controller to request |

## Verification
A stuck or wrongly set service hold bit shows at the ports in two ways. It appears on `dma_req_en` and on read bit 2 one cycle after the cause. It also shows as an interrupt pulse that is missing or extra on the same edge. Threshold arithmetic errors from the word size show directly on the full and empty bits, with no delay, for the same byte count and different `impl_id` values. Fault path faults show as an interrupt that arrives earlier or later than the third edge after the pin falls. In level style, a wrong pending flag shows as `irq` staying high after the masking write, or rising in modes 000 and 001.

// File: rtl/ppt_pkg.sv
// Shared types and helpers for the parallel port service-interrupt controller.
// Assumes the FIFO word size is a power of two bytes.
package ppt_pkg;

    // Writable part of the control byte, bits [7:2]
    typedef struct packed {
        logic [2:0] mode;
        logic       flt_off;
        logic       dma_on;
        logic       svc_hold;
    } ctl_t;

    // Word size as a shift count: ID 0 -> 2 bytes, 1 -> 1 byte, 2 -> 4 bytes
    function automatic logic [1:0] pw_shift(input logic [2:0] id);
        case (id)
            3'd0:    return 2'd1;
            3'd2:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ppt_fifo_status.sv
// Converts a byte occupancy count into word-based free and held counts and
// produces the direction-dependent full and empty flags.
// Assumes fifo_bytes never exceeds FIFO_BYTES.
module ppt_fifo_status #(
    parameter int FIFO_BYTES = 16,
    parameter int CNT_W      = 5
) (
    input  logic             dir,
    input  logic [CNT_W-1:0] fifo_bytes,
    input  logic [1:0]       shift,
    output logic [CNT_W-1:0] free_pw,
    output logic [CNT_W-1:0] avail_pw,
    output logic             full_raw,
    output logic             empty_raw
);
    localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(FIFO_BYTES);

    logic [CNT_W-1:0] free_bytes;
    logic [CNT_W-1:0] pw_bytes;

    // Byte and word counts derived from occupancy
    always_comb begin
        free_bytes = DEPTH_V - fifo_bytes;
        pw_bytes   = CNT_W'(1) << shift;
        free_pw    = free_bytes >> shift;
        avail_pw   = fifo_bytes >> shift;
    end

    // Full and empty meanings depend on direction
    always_comb begin
        if (dir) begin
            full_raw  = (free_bytes == '0);
            empty_raw = (fifo_bytes < pw_bytes);
        end else begin
            full_raw  = (free_bytes < pw_bytes);
            empty_raw = (fifo_bytes == '0);
        end
    end

endmodule

// File: rtl/ppt_ctl_regs.sv
// Holds the control byte and the FIFO error flag, and detects the service
// and fault interrupt events. fault_n is asynchronous and is synchronised here.
module ppt_ctl_regs
    import ppt_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    input  logic             dir,
    input  logic             dma_tc,
    input  logic             fault_n,
    input  logic [CNT_W-1:0] free_pw,
    input  logic [CNT_W-1:0] avail_pw,
    input  logic [CNT_W-1:0] wr_thresh,
    input  logic [CNT_W-1:0] rd_thresh,
    input  logic             full_raw,
    input  logic             empty_raw,
    input  logic             fifo_wr_stb,
    input  logic             fifo_rd_stb,
    output ctl_t             ctl,
    output logic             err_flag,
    output logic             svc_evt,
    output logic             flt_evt,
    output logic             svc_pend,
    output logic             flt_pend
);
    logic [SYNC_STAGES:0] fsync;
    logic flt_low, flt_fall, flt_en_evt, err_evt, thr_hit, tc_hit;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[1:0];

    // Synchronise the fault pin and keep one extra stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) fsync <= '1;
        else        fsync <= {fsync[SYNC_STAGES-1:0], fault_n};
    end

    // Event detection for the service and fault interrupt causes
    always_comb begin
        flt_low    = !fsync[SYNC_STAGES-1];
        flt_fall   = flt_low && fsync[SYNC_STAGES];
        flt_en_evt = reg_wr && ctl.flt_off && !reg_wdata[4] && flt_low;
        flt_evt    = (!ctl.flt_off && flt_fall) || flt_en_evt;
        err_evt    = (!dir && fifo_wr_stb && full_raw) || (dir && fifo_rd_stb && empty_raw);
        thr_hit    = !ctl.dma_on && (dir ? (avail_pw >= rd_thresh) : (free_pw >= wr_thresh));
        tc_hit     = ctl.dma_on && dma_tc;
        svc_evt    = !ctl.svc_hold && (thr_hit || tc_hit || err_evt);
    end

    // Control byte: software writes, hardware sets service hold on any cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '{mode: 3'b000, flt_off: 1'b1, dma_on: 1'b0, svc_hold: 1'b1};
        end else begin
            if (reg_wr)  ctl <= ctl_t'(reg_wdata[7:2]);
            if (svc_evt) ctl.svc_hold <= 1'b1;
        end
    end

    // FIFO misuse flag: set on overwrite or overread, cleared by a control write
    always_ff @(posedge clk) begin
        if (!rst_n)       err_flag <= 1'b0;
        else if (err_evt) err_flag <= 1'b1;
        else if (reg_wr)  err_flag <= 1'b0;
    end

    // Pending flags for level style: service sets win, fault masking wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_pend <= 1'b0;
            flt_pend <= 1'b0;
        end else begin
            if (svc_evt)                     svc_pend <= 1'b1;
            else if (reg_wr && reg_wdata[2]) svc_pend <= 1'b0;
            if (reg_wr && reg_wdata[4])      flt_pend <= 1'b0;
            else if (flt_evt)                flt_pend <= 1'b1;
        end
    end

endmodule

// File: rtl/ppt_irq_drive.sv
// Drives the interrupt line as a fixed-width pulse per event or as a level
// that follows the pending flags. Service pending is ignored in modes 000/001.
module ppt_irq_drive #(
    parameter int PULSE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_irq,
    input  logic [2:0] mode,
    input  logic       evt,
    input  logic       svc_pend,
    input  logic       flt_pend,
    output logic       irq
);
    localparam int PCNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [PCNT_W-1:0] PULSE_V = PCNT_W'(PULSE_CYC);

    logic [PCNT_W-1:0] pcnt;
    logic              mode_ok;

    // Pulse width counter, reloaded by each event in pulsed style
    always_ff @(posedge clk) begin
        if (!rst_n)                 pcnt <= '0;
        else if (evt && !level_irq) pcnt <= PULSE_V;
        else if (pcnt != '0)        pcnt <= pcnt - 1'b1;
    end

    // Select the output form
    always_comb begin
        mode_ok = (mode[2:1] != 2'b00);
        if (level_irq) irq = (svc_pend && mode_ok) || flt_pend;
        else           irq = (pcnt != '0);
    end

endmodule

// File: rtl/ppt_svc_irq_ctl.sv
// Top of the parallel port service-interrupt controller. Combines the word
// based FIFO status, the control byte with its event detection, and the
// interrupt output stage. FIFO storage, bus decode and DMA are external.
module ppt_svc_irq_ctl
    import ppt_pkg::*;
#(
    parameter  int FIFO_BYTES = 16,
    parameter  int PULSE_CYC  = 4,
    localparam int CNT_W      = $clog2(FIFO_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             dir,
    input  logic [CNT_W-1:0] fifo_bytes,
    input  logic [2:0]       impl_id,
    input  logic [CNT_W-1:0] wr_thresh,
    input  logic [CNT_W-1:0] rd_thresh,
    input  logic             fifo_wr_stb,
    input  logic             fifo_rd_stb,
    input  logic             dma_tc,
    input  logic             fault_n,
    input  logic             level_irq,
    output logic             irq,
    output logic             dma_req_en
);
    ctl_t             ctl;
    logic [CNT_W-1:0] free_pw, avail_pw;
    logic             full_raw, empty_raw, err_flag;
    logic             svc_evt, flt_evt, svc_pend, flt_pend;

    ppt_fifo_status #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) status_i (
        .dir(dir), .fifo_bytes(fifo_bytes), .shift(pw_shift(impl_id)),
        .free_pw(free_pw), .avail_pw(avail_pw),
        .full_raw(full_raw), .empty_raw(empty_raw)
    );

    ppt_ctl_regs #(.CNT_W(CNT_W), .SYNC_STAGES(2)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .dir(dir), .dma_tc(dma_tc), .fault_n(fault_n),
        .free_pw(free_pw), .avail_pw(avail_pw),
        .wr_thresh(wr_thresh), .rd_thresh(rd_thresh),
        .full_raw(full_raw), .empty_raw(empty_raw),
        .fifo_wr_stb(fifo_wr_stb), .fifo_rd_stb(fifo_rd_stb),
        .ctl(ctl), .err_flag(err_flag), .svc_evt(svc_evt), .flt_evt(flt_evt),
        .svc_pend(svc_pend), .flt_pend(flt_pend)
    );

    ppt_irq_drive #(.PULSE_CYC(PULSE_CYC)) irq_i (
        .clk(clk), .rst_n(rst_n), .level_irq(level_irq), .mode(ctl.mode),
        .evt(svc_evt || flt_evt), .svc_pend(svc_pend), .flt_pend(flt_pend),
        .irq(irq)
    );

    // Readback and DMA permission
    always_comb begin
        reg_rdata  = {ctl, full_raw || err_flag, empty_raw || err_flag};
        dma_req_en = ctl.dma_on && !ctl.svc_hold;
    end

endmodule

// File: rtl/ppt_svc_irq_ctl_chk.sv
// Temporal checks for the service-interrupt controller, bound to its top.
module ppt_svc_irq_ctl_chk #(
    parameter int FIFO_BYTES = 16,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             level_irq,
    input logic             irq,
    input logic             dma_req_en,
    input logic             dma_tc,
    input logic [7:0]       reg_rdata,
    input logic [CNT_W-1:0] fifo_bytes,
    input logic             svc_evt,
    input logic             flt_evt,
    input logic             err_flag
);
    AST_TC_STOPS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_en && dma_tc |=> !dma_req_en); // R1

    AST_SVC_EVT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        svc_evt && !level_irq |=> irq); // R2

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) && !level_irq && $past(!level_irq) |-> $past(svc_evt || flt_evt)); // R4

    AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        level_irq && (reg_rdata[7:6] == 2'b00) && reg_rdata[4] |-> !irq); // R11

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_bytes <= CNT_W'(FIFO_BYTES)) && reg_rdata[1] && reg_rdata[0] |-> err_flag); // R12
endmodule

bind ppt_svc_irq_ctl ppt_svc_irq_ctl_chk #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .level_irq(level_irq), .irq(irq),
    .dma_req_en(dma_req_en), .dma_tc(dma_tc), .reg_rdata(reg_rdata),
    .fifo_bytes(fifo_bytes), .svc_evt(svc_evt), .flt_evt(flt_evt),
    .err_flag(err_flag)
);

// File: tb/ppt_svc_irq_ctl_tb_top.sv
// Directed bench for the service-interrupt controller; one task per scenario.
module ppt_svc_irq_ctl_tb_top;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             dir = 1'b0;
    logic [CNT_W-1:0] fifo_bytes = '0;
    logic [2:0]       impl_id = 3'd1;
    logic [CNT_W-1:0] wr_thresh = 5'd1;
    logic [CNT_W-1:0] rd_thresh = 5'd1;
    logic             fifo_wr_stb = 1'b0;
    logic             fifo_rd_stb = 1'b0;
    logic             dma_tc = 1'b0;
    logic             fault_n = 1'b1;
    logic             level_irq = 1'b0;
    logic             irq;
    logic             dma_req_en;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    ppt_svc_irq_ctl #(.FIFO_BYTES(16), .PULSE_CYC(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dir(dir), .fifo_bytes(fifo_bytes),
        .impl_id(impl_id), .wr_thresh(wr_thresh), .rd_thresh(rd_thresh),
        .fifo_wr_stb(fifo_wr_stb), .fifo_rd_stb(fifo_rd_stb), .dma_tc(dma_tc),
        .fault_n(fault_n), .level_irq(level_irq), .irq(irq), .dma_req_en(dma_req_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called just after a negedge; returns at the next negedge
    task automatic wr(input logic [7:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Counts high samples of irq starting at the current negedge
    task automatic pulse_len(output int n);
        n = 0;
        while (irq && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Counts irq high samples over a window
    task automatic quiet(input int cyc, output int highs);
        highs = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (irq) highs++;
        end
    endtask

    task automatic t_reset();
        chk("R13 ctl byte", reg_rdata, 8'h15);
        chk("R13 irq", irq, 0);
        chk("R13 dma_req_en", dma_req_en, 0);
    endtask

    task automatic t_fwd_thresh();
        int n;
        dir = 0; impl_id = 1; fifo_bytes = 12; wr_thresh = 6;
        wr(8'h70);
        repeat (2) @(negedge clk);
        chk("R2 below threshold hold", reg_rdata[2], 0);
        chk("R2 below threshold irq", irq, 0);
        fifo_bytes = 10;
        @(negedge clk);
        chk("R2 threshold sets hold", reg_rdata[2], 1);
        chk("R2 threshold irq", irq, 1);
        pulse_len(n);
        chk("R10 pulse width", n, 4);
    endtask

    task automatic t_rev_thresh();
        int n;
        dir = 1; impl_id = 0; fifo_bytes = 5; rd_thresh = 3;
        wr(8'h70);
        repeat (2) @(negedge clk);
        chk("R3 two words held no event", reg_rdata[2], 0);
        fifo_bytes = 6;
        @(negedge clk);
        chk("R3 three words sets hold", reg_rdata[2], 1);
        chk("R3 irq", irq, 1);
        pulse_len(n);
    endtask

    task automatic t_flags();
        dir = 1; impl_id = 0; fifo_bytes = 1; #1;
        chk("R6 rev empty below word", reg_rdata[0], 1);
        fifo_bytes = 2; #1;
        chk("R6 rev one word not empty", reg_rdata[0], 0);
        impl_id = 2; fifo_bytes = 3; #1;
        chk("R7 4-byte word rev empty", reg_rdata[0], 1);
        fifo_bytes = 15; #1;
        chk("R6 rev one byte free not full", reg_rdata[1], 0);
        fifo_bytes = 16; #1;
        chk("R6 rev full", reg_rdata[1], 1);
        dir = 0; fifo_bytes = 13; #1;
        chk("R5 fwd full below word free", reg_rdata[1], 1);
        fifo_bytes = 12; #1;
        chk("R5 fwd one word free", reg_rdata[1], 0);
        fifo_bytes = 0; #1;
        chk("R5 fwd empty", reg_rdata[0], 1);
        fifo_bytes = 1; #1;
        chk("R5 fwd one byte not empty", reg_rdata[0], 0);
        impl_id = 0; fifo_bytes = 15; #1;
        chk("R7 2-byte word fwd full", reg_rdata[1], 1);
        impl_id = 5; #1;
        chk("R7 other id 1-byte word", reg_rdata[1], 0);
        @(negedge clk);
    endtask

    task automatic t_dma();
        int n;
        dir = 0; impl_id = 1; fifo_bytes = 0; wr_thresh = 1;
        wr(8'h78);
        @(negedge clk);
        chk("R1 dma runs", dma_req_en, 1);
        chk("R1 threshold ignored", reg_rdata[2], 0);
        chk("R1 no irq", irq, 0);
        dma_tc = 1;
        @(negedge clk);
        dma_tc = 0;
        chk("R1 tc stops dma", dma_req_en, 0);
        chk("R1 tc sets hold", reg_rdata[2], 1);
        chk("R1 tc irq", irq, 1);
        pulse_len(n);
        wr(8'h74);
        chk("R1 dma disabled", dma_req_en, 0);
    endtask

    task automatic t_sw_hold();
        int h;
        dir = 0; fifo_bytes = 16; wr_thresh = 1;
        wr(8'h70);
        quiet(3, h);
        chk("R4 armed no cause", h, 0);
        wr(8'h74);
        quiet(5, h);
        chk("R4 software hold no irq", h, 0);
        fifo_bytes = 0;
        quiet(5, h);
        chk("R4 held blocks threshold", h, 0);
    endtask

    task automatic t_error();
        int n;
        dir = 0; impl_id = 1; fifo_bytes = 16;
        wr(8'h70);
        fifo_wr_stb = 1;
        @(negedge clk);
        fifo_wr_stb = 0;
        chk("R12 overwrite flags", reg_rdata[1:0], 3);
        chk("R12 overwrite irq", irq, 1);
        pulse_len(n);
        wr(8'h74);
        chk("R12 cleared by write", reg_rdata[1:0], 2);
        dir = 1; fifo_bytes = 0;
        wr(8'h70);
        fifo_rd_stb = 1;
        @(negedge clk);
        fifo_rd_stb = 0;
        chk("R12 overread flags", reg_rdata[1:0], 3);
        chk("R12 overread hold", reg_rdata[2], 1);
        pulse_len(n);
        wr(8'h74);
        chk("R12 overread cleared", reg_rdata[1:0], 1);
    endtask

    task automatic t_fault();
        int n, h;
        dir = 0; fifo_bytes = 16;
        wr(8'h64);
        quiet(2, h);
        chk("R8 idle no irq", h, 0);
        fault_n = 0;
        @(negedge clk);
        chk("R8 edge 1 quiet", irq, 0);
        @(negedge clk);
        chk("R8 edge 2 quiet", irq, 0);
        @(negedge clk);
        chk("R8 fall irq on third edge", irq, 1);
        pulse_len(n);
        chk("R10 fault pulse width", n, 4);
        wr(8'h74);
        fault_n = 1;
        quiet(4, h);
        fault_n = 0;
        quiet(6, h);
        chk("R8 masked fall ignored", h, 0);
    endtask

    task automatic t_fault_enable();
        int n;
        wr(8'h64);
        chk("R9 unmask while low irq", irq, 1);
        pulse_len(n);
    endtask

    task automatic t_level();
        int h;
        fault_n = 1;
        wr(8'h14);
        quiet(6, h);
        level_irq = 1;
        dir = 0; fifo_bytes = 0; wr_thresh = 1;
        wr(8'h10);
        @(negedge clk);
        chk("R11 event in mode 000", reg_rdata[2], 1);
        quiet(3, h);
        chk("R11 mode 000 suppressed", h, 0);
        wr(8'h70);
        @(negedge clk);
        chk("R11 level follows pending", irq, 1);
        wr(8'h74);
        chk("R11 masking write drops irq", irq, 0);
        quiet(3, h);
        chk("R11 stays low", h, 0);
        level_irq = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fwd_thresh();
        t_rev_thresh();
        t_flags();
        t_dma();
        t_sw_hold();
        t_error();
        t_fault();
        t_fault_enable();
        t_level();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule